// File: doc/BRIEF.md
# Machine Timer Register Block

This block keeps a free-running 64-bit time counter and a 64-bit compare value, and drives a timer interrupt line whenever the counter has reached the compare value. A host reaches both registers over a simple single-cycle request/response port. Each request carries a byte address, a size code, write data and byte strobes. One cycle later the port returns a response with read data and an error flag.

Software on a narrow host reaches each register as two 32-bit halves. A wide host may also use a single naturally aligned 64-bit access, which reads or writes all 64 bits in one cycle. A build parameter turns 64-bit accesses off, so that they return an error and software falls back to paired 32-bit halves. The counter advances on each cycle in which the tick-enable input is high. A software write to the counter in the same cycle wins over the increment for the bytes it writes.

Top module: `mtimer_regs`

## Requirements
- R1: After reset the counter is 0, the compare register is all ones, `timer_irq` is low and `rsp_valid` is low.
- R2: Register offsets: compare low half at 0x0, compare high half at 0x4, counter low half at 0x8, counter high half at 0xC. A 32-bit access uses size code 2 with an address that is a multiple of 4. It takes its write data from `req_wdata[31:0]` and its strobes from `req_strb[3:0]`, and it returns data on `rsp_rdata[31:0]` with `rsp_rdata[63:32]` = 0.
- R3: A 64-bit access uses size code 3 at offset 0x0 or 0x8. It reads or writes all 64 bits of the register in one cycle, little-endian: bits 31:0 are the low half and strobe bit n covers data byte n.
- R4: Every request cycle yields exactly one response cycle on the next clock. Read data is the register value in the request cycle, before that cycle's write or increment. Writes return `rsp_rdata` = 0.
- R5: With no write to the counter, each cycle with `tick_en` high adds one to the counter, wrapping from all ones to 0. Without `tick_en` the counter holds.
- R6: A write to the counter in a tick cycle sets the written bytes to the write data. The other bytes take their value from the incremented counter, including any carry.
- R7: Only the bytes whose strobe bit is set are changed by a write.
- R8: `timer_irq` is high exactly when the counter, as an unsigned value, is greater than or equal to the compare value. It follows register changes without a latch.
- R9: A misaligned access, any access at offset 0x10 or above, and size codes 0 and 1 return `rsp_err` = 1 with `rsp_rdata` = 0. Such an access changes no register; the counter still ticks.
- R10: With `ALLOW_64` = 0, every size-code-3 access returns `rsp_err` = 1 and changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counter increment enable |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset within the block |
| req_size | input | 2 | Size code: 2 = 32-bit, 3 = 64-bit |
| req_wdata | input | 64 | Write data |
| req_strb | input | 8 | Byte strobes |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Error response |
| rsp_rdata | output | 64 | Read data |
| timer_irq | output | 1 | Timer interrupt |

## Verification
On every cycle, the assertions check four things: one response per request, zero data and unchanged compare contents on any error, hold-or-increment of the counter while the bus is idle, and rejection of 64-bit sizes when they are disabled. The bench's scenarios show the things a cycle-local property cannot see. These are the address map and the half and lane placement, strobe merging, priority of a write over a simultaneous tick with carry into unwritten bytes, the compare threshold, and the wrap of the counter. A second instance built without 64-bit support shows that its rejected writes leave the compare register untouched.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;
    localparam int REG_W  = 64;
    localparam int HALF_W = REG_W / 2;
    localparam int BE_W   = REG_W / 8;
    localparam int HBE_W  = BE_W / 2;
    localparam int NREGS  = 2;

    localparam logic [1:0] SIZE_WORD  = 2'd2;
    localparam logic [1:0] SIZE_DWORD = 2'd3;

    typedef struct packed {
        logic              ok;
        logic              sel_time;
        logic              upper;
        logic              dword;
        logic [BE_W-1:0]   be;
        logic [REG_W-1:0]  wdata;
    } dec_t;

    typedef struct packed {
        logic              valid;
        logic              err;
        logic [REG_W-1:0]  rdata;
    } rsp_t;
endpackage

// File: rtl/mtimer_decode.sv
module mtimer_decode
    import mtimer_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter bit ALLOW_64 = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic [BE_W-1:0]   strb,
    input  logic [REG_W-1:0]  wdata,
    output dec_t              dec
);
    logic mapped;
    logic word_ok;
    logic dword_ok;

    always_comb begin
        mapped   = (addr >> 4) == '0;
        word_ok  = (size == SIZE_WORD) && (addr[1:0] == 2'b00);
        dword_ok = ALLOW_64 && (size == SIZE_DWORD) && (addr[2:0] == 3'b000);

        dec          = '0;
        dec.ok       = mapped && (word_ok || dword_ok);
        dec.sel_time = addr[3];
        dec.upper    = addr[2];
        dec.dword    = dword_ok;
        if (dword_ok) begin
            dec.be    = strb;
            dec.wdata = wdata;
        end else if (addr[2]) begin
            dec.be    = {strb[HBE_W-1:0], {HBE_W{1'b0}}};
            dec.wdata = {wdata[HALF_W-1:0], {HALF_W{1'b0}}};
        end else begin
            dec.be    = {{HBE_W{1'b0}}, strb[HBE_W-1:0]};
            dec.wdata = {{HALF_W{1'b0}}, wdata[HALF_W-1:0]};
        end
    end
endmodule

// File: rtl/mtimer_word.sv
module mtimer_word
    import mtimer_pkg::*;
#(
    parameter logic [REG_W-1:0] RST_VAL = '0,
    parameter bit               COUNTS  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic [BE_W-1:0]   be,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  val_q
);
    logic [REG_W-1:0] val_d;

    always_comb begin
        val_d = (COUNTS && inc) ? val_q + 1'b1 : val_q;
        for (int b = 0; b < BE_W; b++) begin
            if (be[b]) val_d[b*8 +: 8] = wdata[b*8 +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) val_q <= RST_VAL;
        else        val_q <= val_d;
    end
endmodule

// File: rtl/mtimer_regs.sv
module mtimer_regs
    import mtimer_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter bit ALLOW_64 = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [REG_W-1:0]  req_wdata,
    input  logic [BE_W-1:0]   req_strb,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [REG_W-1:0]  rsp_rdata,
    output logic              timer_irq
);
    dec_t             dec;
    logic [REG_W-1:0] reg_q [NREGS];
    logic [REG_W-1:0] cmp_val;
    logic [REG_W-1:0] time_val;
    logic             wr_ok;
    rsp_t             rsp_d;
    rsp_t             rsp_q;

    mtimer_decode #(.ADDR_W(ADDR_W), .ALLOW_64(ALLOW_64)) u_dec (
        .addr (req_addr),
        .size (req_size),
        .strb (req_strb),
        .wdata(req_wdata),
        .dec  (dec)
    );

    assign wr_ok = req_valid && req_write && dec.ok;

    // index 0 = compare register, index 1 = time counter
    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        localparam bit               IS_TIME = (g == 1);
        localparam logic [REG_W-1:0] RV      = IS_TIME ? '0 : '1;
        logic [BE_W-1:0] be_g;
        assign be_g = (wr_ok && (dec.sel_time == IS_TIME)) ? dec.be : '0;
        mtimer_word #(.RST_VAL(RV), .COUNTS(IS_TIME)) u_word (
            .clk  (clk),
            .rst_n(rst_n),
            .inc  (tick_en),
            .be   (be_g),
            .wdata(dec.wdata),
            .val_q(reg_q[g])
        );
    end

    assign cmp_val  = reg_q[0];
    assign time_val = reg_q[1];

    always_comb begin
        logic [REG_W-1:0] full;
        full        = dec.sel_time ? time_val : cmp_val;
        rsp_d       = '0;
        rsp_d.valid = req_valid;
        rsp_d.err   = req_valid && !dec.ok;
        if (req_valid && dec.ok && !req_write) begin
            if (dec.dword)      rsp_d.rdata = full;
            else if (dec.upper) rsp_d.rdata = {{HALF_W{1'b0}}, full[REG_W-1:HALF_W]};
            else                rsp_d.rdata = {{HALF_W{1'b0}}, full[HALF_W-1:0]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_err   = rsp_q.err;
    assign rsp_rdata = rsp_q.rdata;
    assign timer_irq = time_val >= cmp_val;
endmodule

// File: rtl/mtimer_regs_chk.sv
module mtimer_regs_chk
    import mtimer_pkg::*;
#(
    parameter bit ALLOW_64 = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             req_valid,
    input logic [1:0]       req_size,
    input logic             rsp_valid,
    input logic             rsp_err,
    input logic [REG_W-1:0] rsp_rdata,
    input logic [REG_W-1:0] cmp_val,
    input logic [REG_W-1:0] time_val
);
    assert_rsp_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_no_spurious_rsp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_err_data_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && rsp_rdata == '0));

    assert_err_cmp_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> $stable(cmp_val));

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && !tick_en) |=> $stable(time_val));

    assert_tick_inc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && tick_en) |=> (time_val == $past(time_val) + 1'b1));

    assert_reject_dword_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == SIZE_DWORD && !ALLOW_64) |=> rsp_err);
endmodule

bind mtimer_regs mtimer_regs_chk #(.ALLOW_64(ALLOW_64)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .req_valid(req_valid),
    .req_size (req_size),
    .rsp_valid(rsp_valid),
    .rsp_err  (rsp_err),
    .rsp_rdata(rsp_rdata),
    .cmp_val  (cmp_val),
    .time_val (time_val)
);

// File: tb/mtimer_regs_test.sv
module mtimer_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [63:0] req_wdata = '0;
    logic [7:0]  req_strb = '0;
    logic        rsp_valid, rsp_err, timer_irq;
    logic [63:0] rsp_rdata;
    logic        n_valid, n_err, n_irq;
    logic [63:0] n_rdata;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    mtimer_regs uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .req_valid(req_valid),
        .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata), .req_strb(req_strb), .rsp_valid(rsp_valid),
        .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .timer_irq(timer_irq));

    mtimer_regs #(.ALLOW_64(1'b0)) uut_n64 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .req_valid(req_valid),
        .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata), .req_strb(req_strb), .rsp_valid(n_valid),
        .rsp_err(n_err), .rsp_rdata(n_rdata), .timer_irq(n_irq));

    typedef struct packed {
        logic        wr;
        logic [1:0]  sz;
        logic [11:0] addr;
        logic [63:0] wd;
        logic [7:0]  sb;
        logic        ee;
        logic [63:0] er;
    } vec_t;

    // Covers R2, R3, R7, R9 in sequence from the reset state, tick_en low.
    localparam vec_t VECS [0:15] = '{
        '{1'b0, 2'd2, 12'h000, 64'h0, 8'h00, 1'b0, 64'h00000000FFFFFFFF},
        '{1'b0, 2'd3, 12'h008, 64'h0, 8'h00, 1'b0, 64'h0},
        '{1'b1, 2'd2, 12'h008, 64'h11223344, 8'h0F, 1'b0, 64'h0},
        '{1'b1, 2'd2, 12'h00C, 64'h55667788, 8'h0F, 1'b0, 64'h0},
        '{1'b0, 2'd3, 12'h008, 64'h0, 8'h00, 1'b0, 64'h5566778811223344},
        '{1'b0, 2'd2, 12'h00C, 64'h0, 8'h00, 1'b0, 64'h0000000055667788},
        '{1'b1, 2'd3, 12'h000, 64'h0123456789ABCDEF, 8'hFF, 1'b0, 64'h0},
        '{1'b0, 2'd2, 12'h004, 64'h0, 8'h00, 1'b0, 64'h0000000001234567},
        '{1'b1, 2'd2, 12'h000, 64'hAAAAAAAA, 8'h05, 1'b0, 64'h0},
        '{1'b0, 2'd2, 12'h000, 64'h0, 8'h00, 1'b0, 64'h0000000089AACDAA},
        '{1'b0, 2'd2, 12'h002, 64'h0, 8'h00, 1'b1, 64'h0},
        '{1'b0, 2'd3, 12'h004, 64'h0, 8'h00, 1'b1, 64'h0},
        '{1'b1, 2'd2, 12'h010, 64'h0, 8'h0F, 1'b1, 64'h0},
        '{1'b0, 2'd0, 12'h000, 64'h0, 8'h00, 1'b1, 64'h0},
        '{1'b1, 2'd1, 12'h004, 64'h0, 8'h0F, 1'b1, 64'h0},
        '{1'b0, 2'd3, 12'h000, 64'h0, 8'h00, 1'b0, 64'h0123456789AACDAA}
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [1:0] sz, input logic [11:0] a,
                          input logic [63:0] wd, input logic [7:0] sb, input logic tk);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a;
        req_wdata = wd; req_strb = sb; tick_en = tk;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_strb = '0; tick_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_up();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        do_reset();
        @(negedge clk);
        // R1: reset outputs
        check(!rsp_valid && !timer_irq, "R1 reset outputs", {rsp_valid, timer_irq}, 0);

        for (int i = 0; i < 16; i++) begin
            access(VECS[i].wr, VECS[i].sz, VECS[i].addr, VECS[i].wd, VECS[i].sb, 1'b0);
            check(rsp_valid && rsp_err == VECS[i].ee && rsp_rdata == VECS[i].er,
                  $sformatf("R2,R3,R7,R9 vector %0d", i), rsp_rdata, VECS[i].er);
        end

        // R8: counter above compare raises irq
        access(1'b1, 2'd3, 12'h000, 64'h10, 8'hFF, 1'b0);
        check(timer_irq == 1'b1, "R8 time>cmp", timer_irq, 1);
        access(1'b1, 2'd3, 12'h008, 64'h0F, 8'hFF, 1'b0);
        check(timer_irq == 1'b0, "R8 time<cmp", timer_irq, 0);
        @(negedge clk); tick_en = 1'b1;
        @(negedge clk); tick_en = 1'b0;
        check(timer_irq == 1'b1, "R8 time==cmp after tick", timer_irq, 1);
        access(1'b1, 2'd2, 12'h004, 64'h1, 8'h0F, 1'b0);
        check(timer_irq == 1'b0, "R8 cmp high half written", timer_irq, 0);

        // R5: wrap
        access(1'b1, 2'd3, 12'h008, 64'hFFFFFFFFFFFFFFFF, 8'hFF, 1'b0);
        @(negedge clk); tick_en = 1'b1;
        @(negedge clk); tick_en = 1'b0;
        access(1'b0, 2'd3, 12'h008, 64'h0, 8'h00, 1'b0);
        check(rsp_rdata == 64'h0, "R5 wrap to zero", rsp_rdata, 64'h0);

        // R6: write low half during tick, carry lands in high half
        access(1'b1, 2'd3, 12'h008, 64'h00000001FFFFFFFF, 8'hFF, 1'b0);
        access(1'b1, 2'd2, 12'h008, 64'h5, 8'h0F, 1'b1);
        access(1'b0, 2'd3, 12'h008, 64'h0, 8'h00, 1'b0);
        check(rsp_rdata == 64'h0000000200000005, "R6 write beats tick", rsp_rdata,
              64'h0000000200000005);

        // R4: read returns pre-update value; writes return zero data
        access(1'b1, 2'd3, 12'h008, 64'd100, 8'hFF, 1'b0);
        check(rsp_valid && !rsp_err && rsp_rdata == 64'h0, "R4 write rdata zero", rsp_rdata, 0);
        access(1'b0, 2'd3, 12'h008, 64'h0, 8'h00, 1'b1);
        check(rsp_rdata == 64'd100, "R4 read before tick", rsp_rdata, 64'd100);
        access(1'b0, 2'd3, 12'h008, 64'h0, 8'h00, 1'b0);
        check(rsp_rdata == 64'd101, "R4 tick applied", rsp_rdata, 64'd101);
        @(negedge clk);
        check(!rsp_valid, "R4 single response", rsp_valid, 0);

        // R9: erroneous write still lets the counter tick
        access(1'b1, 2'd2, 12'h00A, 64'h0, 8'h0F, 1'b1);
        check(rsp_err, "R9 misaligned write error", rsp_err, 1);
        access(1'b0, 2'd3, 12'h008, 64'h0, 8'h00, 1'b0);
        check(rsp_rdata == 64'd102, "R9 counter ticked, not written", rsp_rdata, 64'd102);

        // R10: instance without 64-bit support
        do_reset();
        access(1'b1, 2'd3, 12'h000, 64'h0, 8'hFF, 1'b0);
        check(n_valid && n_err, "R10 dword write rejected", n_err, 1);
        check(!rsp_err && timer_irq, "R3 dword write accepted", timer_irq, 1);
        check(!n_irq, "R10 cmp untouched irq low", n_irq, 0);
        access(1'b0, 2'd2, 12'h000, 64'h0, 8'h00, 1'b0);
        check(!n_err && n_rdata == 64'hFFFFFFFF, "R10 cmp low half intact", n_rdata,
              64'hFFFFFFFF);
        check(rsp_rdata == 64'h0, "R3 cmp cleared", rsp_rdata, 64'h0);
        access(1'b0, 2'd3, 12'h008, 64'h0, 8'h00, 1'b0);
        check(n_err && n_rdata == 64'h0, "R10 dword read rejected", n_rdata, 64'h0);

        finish_up();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            finish_up();
        end
    end
endmodule